// File: doc/BRIEF.md
# Low-Power Clock Domain Controller

This block decides, cycle by cycle, which clock branches of a chip may advance. It works in one sampling domain. Each candidate source (PLL, crystal, external clock) arrives as a one-cycle tick, and every branch output is a clock enable derived from the tick of the source that branch currently uses. The downstream glitch-free clock cells act on these enables. The always-on branch also gets a source-select code.

A strap picks between PLL mode and external-clock mode for the main source. A stop request moves the block into a low-power state in which the core-module and primary-protection-domain branches are gated off. The pin-clock branch and its slow chip-select strobe keep running. The secondary branch, which feeds the protection timers, also keeps running, but it may change source: it uses the crystal when the keep flag is clear, stays on the PLL when the flag is set, and always uses the external clock in external mode. A wake request starts a settle window of fixed length. Only after that window ends are the gated branches released. Every change of the secondary source takes place inside a short window in which the secondary enable is held low.

Top module: `lpcc_top`

## Requirements
- R1: While reset is asserted and right after it is released, the block is in the running state (`lp_active_o`=0), `sec_sel_o` is 2'b00 (PLL), and the chip-select strobe divider starts from zero.
- R2: The main tick is `ext_tick_i` when `ext_mode_i`=1 and `pll_tick_i` otherwise. `core_en_o` and `prim_en_o` equal the main tick while `lp_active_o`=0 and are 0 while `lp_active_o`=1.
- R3: A `stop_req_i` sampled in the running state sets `lp_active_o` from the next cycle. A `wake_req_i` sampled in the running state has no effect. When both arrive together, stop wins.
- R4: A `wake_req_i` sampled in the low-power state (with no stop request) starts a settle window, and `lp_active_o` clears exactly SETTLE_CYC (default 16) clock edges after the edge that sampled the wake. A `stop_req_i` during the settle window returns the block to the stop state.
- R5: `clkout_en_o` equals the main tick in every state. `e_en_o` is high together with every EDIV-th (default 8th) `clkout_en_o` pulse, counted from reset.
- R6: The target secondary source is 2'b10 (external) when `ext_mode_i`=1. Otherwise it is 2'b01 (crystal) when `lp_active_o`=1 and `keep_pll_i`=0, and 2'b00 (PLL) in all other cases. Outside a switch window, `sec_en_o` equals the tick of the source named by `sec_sel_o`.
- R7: When the target differs from `sec_sel_o`, a switch window of 2*HALF cycles (default 4) opens, during which `sec_en_o` is 0. `sec_sel_o` takes the target value HALF cycles into the window, so that the enable is low on both sides of the change.
- R8: `sec_sel_o` never holds the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pll_tick_i | input | 1 | One-cycle tick per PLL clock period |
| xtal_tick_i | input | 1 | One-cycle tick per crystal clock period |
| ext_tick_i | input | 1 | One-cycle tick per external clock period |
| ext_mode_i | input | 1 | Strap: 1 selects external-clock mode |
| keep_pll_i | input | 1 | Keep the secondary branch on the PLL in low power |
| stop_req_i | input | 1 | Request entry into low-power stop |
| wake_req_i | input | 1 | Request exit from low-power stop |
| clkout_en_o | output | 1 | Enable for the pin clock branch |
| core_en_o | output | 1 | Enable for the internal module branch |
| prim_en_o | output | 1 | Enable for the primary protection-domain branch |
| sec_en_o | output | 1 | Enable for the always-on secondary branch |
| e_en_o | output | 1 | Slow chip-select strobe enable |
| sec_sel_o | output | 2 | Secondary source code: 00 PLL, 01 crystal, 10 external |
| lp_active_o | output | 1 | 1 while in stop or in the wake settle window |

## Verification
A wrong mode state would show up in `core_en_o` and `prim_en_o` on the very next tick. Either a stop would fail to gate them, or they would return before the full settle window had run, which the cycle-exact compare catches on the first early pulse. A corrupted switch counter or select register shows up at once in `sec_sel_o` or `sec_en_o`: a pulse would appear inside the blank window, or the select would change on the wrong cycle. A divider that drifts would place `e_en_o` against the wrong `clkout_en_o` pulse within at most EDIV pulses.

// File: rtl/lpcc_pkg.sv
package lpcc_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } lp_state_e;

  typedef enum logic [1:0] {
    SRC_PLL  = 2'b00,
    SRC_XTAL = 2'b01,
    SRC_EXT  = 2'b10
  } src_sel_e;

  // tick of the source named by a select code
  function automatic logic pick_tick(src_sel_e s, logic p, logic x, logic e);
    logic t;
    case (s)
      SRC_XTAL: t = x;
      SRC_EXT:  t = e;
      default:  t = p;
    endcase
    return t;
  endfunction

  // desired source of the always-on branch
  function automatic src_sel_e sec_target(logic ext_mode, logic lp, logic keep);
    src_sel_e r;
    if (ext_mode)        r = SRC_EXT;
    else if (lp && !keep) r = SRC_XTAL;
    else                  r = SRC_PLL;
    return r;
  endfunction

endpackage

// File: rtl/lpcc_mode_fsm.sv
module lpcc_mode_fsm
  import lpcc_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic wake_req_i,
  output logic lp_active_o,
  output logic settle_phase_o,
  output logic settle_done_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  lp_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign settle_done_o  = (state_q == ST_SETTLE) && (cnt_q == LAST) && !stop_req_i;
  assign settle_phase_o = (state_q == ST_SETTLE);
  assign lp_active_o    = (state_q != ST_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_RUN: begin
        if (stop_req_i) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (!stop_req_i && wake_req_i) begin
          state_d = ST_SETTLE;
          cnt_d   = '0;
        end
      end
      ST_SETTLE: begin
        if (stop_req_i)         state_d = ST_STOP;
        else if (settle_done_o) state_d = ST_RUN;
        else                    cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/lpcc_sec_switch.sv
module lpcc_sec_switch
  import lpcc_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] target_i,
  input  logic       pll_tick_i,
  input  logic       xtal_tick_i,
  input  logic       ext_tick_i,
  output logic [1:0] sel_o,
  output logic       busy_o,
  output logic       sel_update_o,
  output logic       sec_en_o
);
  localparam int SPAN = 2 * HALF;
  localparam int SW   = $clog2(SPAN + 1);
  localparam logic [SW-1:0] MID = SW'(HALF - 1);
  localparam logic [SW-1:0] END = SW'(SPAN - 1);

  src_sel_e      sel_q;
  logic          busy_q;
  logic [SW-1:0] scnt_q;
  logic          start;

  assign start        = !busy_q && (target_i != sel_q);
  assign sel_update_o = busy_q && (scnt_q == MID);
  assign sel_o        = sel_q;
  assign busy_o       = busy_q;
  assign sec_en_o     = !busy_q && pick_tick(sel_q, pll_tick_i, xtal_tick_i, ext_tick_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sel_q  <= SRC_PLL;
      busy_q <= 1'b0;
      scnt_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      scnt_q <= '0;
    end else if (busy_q) begin
      if (sel_update_o) sel_q <= src_sel_e'(target_i);
      if (scnt_q == END) begin
        busy_q <= 1'b0;
        scnt_q <= '0;
      end else begin
        scnt_q <= scnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpcc_ediv.sv
module lpcc_ediv #(
  parameter int EDIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic strobe_o
);
  localparam int CW = $clog2(EDIV + 1);
  localparam logic [CW-1:0] LAST = CW'(EDIV - 1);

  logic [CW-1:0] cnt_q;

  assign strobe_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (strobe_o) cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lpcc_top.sv
module lpcc_top
  import lpcc_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int HALF       = 2,
  parameter int EDIV       = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pll_tick_i,
  input  logic       xtal_tick_i,
  input  logic       ext_tick_i,
  input  logic       ext_mode_i,
  input  logic       keep_pll_i,
  input  logic       stop_req_i,
  input  logic       wake_req_i,
  output logic       clkout_en_o,
  output logic       core_en_o,
  output logic       prim_en_o,
  output logic       sec_en_o,
  output logic       e_en_o,
  output logic [1:0] sec_sel_o,
  output logic       lp_active_o
);
  localparam int NGATED = 2;

  logic       main_tick;
  logic       lp_active;
  logic       settle_phase;
  logic       settle_done;
  logic       sw_busy;
  logic       sel_update;
  logic [1:0] sel_q;
  logic [1:0] target;
  logic [NGATED-1:0] gated;

  assign main_tick = ext_mode_i ? ext_tick_i : pll_tick_i;
  assign target    = sec_target(ext_mode_i, lp_active, keep_pll_i);

  lpcc_mode_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk_i, .rst_ni, .stop_req_i, .wake_req_i,
    .lp_active_o   (lp_active),
    .settle_phase_o(settle_phase),
    .settle_done_o (settle_done)
  );

  lpcc_sec_switch #(.HALF(HALF)) u_sw (
    .clk_i, .rst_ni,
    .target_i    (target),
    .pll_tick_i, .xtal_tick_i, .ext_tick_i,
    .sel_o       (sel_q),
    .busy_o      (sw_busy),
    .sel_update_o(sel_update),
    .sec_en_o    (sec_en_o)
  );

  lpcc_ediv #(.EDIV(EDIV)) u_ediv (
    .clk_i, .rst_ni,
    .tick_i  (main_tick),
    .strobe_o(e_en_o)
  );

  // branches stopped while in low power
  for (genvar g = 0; g < NGATED; g++) begin : g_gate
    assign gated[g] = main_tick && !lp_active;
  end

  assign clkout_en_o = main_tick;
  assign core_en_o   = gated[0];
  assign prim_en_o   = gated[1];
  assign sec_sel_o   = sel_q;
  assign lp_active_o = lp_active;
endmodule

// File: rtl/lpcc_checker.sv
module lpcc_checker #(
  parameter int SETTLE_CYC = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_req_i,
  input logic       lp_active,
  input logic       settle_phase,
  input logic       settle_done,
  input logic       sw_busy,
  input logic       sel_update,
  input logic [1:0] sel_q,
  input logic       core_en_o,
  input logic       prim_en_o,
  input logic       sec_en_o,
  input logic       e_en_o,
  input logic       clkout_en_o
);
  localparam int KW = $clog2(SETTLE_CYC + 2);
  logic [KW-1:0] run_len;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)           run_len <= '0;
    else if (!settle_phase) run_len <= '0;
    else if (run_len != KW'(SETTLE_CYC + 1)) run_len <= run_len + 1'b1;
  end

  p_gate_in_lp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_active |-> (!core_en_o && !prim_en_o));

  p_stop_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lp_active && stop_req_i) |=> lp_active);

  p_settle_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lp_active) |-> (run_len == KW'(SETTLE_CYC)));

  p_exit_by_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_done |=> !lp_active);

  p_estrobe_in_clkout_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_en_o |-> clkout_en_o);

  p_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_busy |-> !sec_en_o);

  p_sel_change_blanked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (sw_busy && $past(sw_busy) && $past(sel_update)));

  p_sel_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q != 2'b11);
endmodule

bind lpcc_top lpcc_checker #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i, .rst_ni, .stop_req_i, .lp_active, .settle_phase, .settle_done,
  .sw_busy, .sel_update, .sel_q, .core_en_o, .prim_en_o, .sec_en_o,
  .e_en_o, .clkout_en_o
);

// File: tb/lpcc_top_tb.sv
module lpcc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 16;
  localparam int HALFW  = 2;
  localparam int EDIVN  = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pll_tick_i = 0, xtal_tick_i = 0, ext_tick_i = 0;
  logic ext_mode_i = 0, keep_pll_i = 0, stop_req_i = 0, wake_req_i = 0;
  logic clkout_en_o, core_en_o, prim_en_o, sec_en_o, e_en_o, lp_active_o;
  logic [1:0] sec_sel_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_mode;   // 0 run, 1 stopped, 2 settling
  int m_cnt, m_sel, m_scnt, m_ediv;
  bit m_busy;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lpcc_top #(.SETTLE_CYC(SETTLE), .HALF(HALFW), .EDIV(EDIVN)) dut_i (.*);

  function automatic bit src_tick(int s, bit p, bit x, bit e);
    return (s == 1) ? x : (s == 2) ? e : p;
  endfunction

  function automatic int want_src(bit ext, bit lp, bit keep);
    if (ext) return 2;
    return (lp && !keep) ? 1 : 0;
  endfunction

  task automatic cmp(string what, string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_cnt = 0; m_sel = 0; m_scnt = 0; m_ediv = 0; m_busy = 0;
  endtask

  task automatic check_outputs();
    bit mt, lp;
    mt = ext_mode_i ? ext_tick_i : pll_tick_i;
    lp = (m_mode != 0);
    cmp("lp_active", "R3", int'(lp_active_o), int'(lp));
    cmp("core_en", "R2", int'(core_en_o), int'(mt && !lp));
    cmp("prim_en", "R2", int'(prim_en_o), int'(mt && !lp));
    cmp("clkout_en", "R5", int'(clkout_en_o), int'(mt));
    cmp("e_en", "R5", int'(e_en_o), int'(mt && m_ediv == EDIVN-1));
    cmp("sec_sel", "R6", int'(sec_sel_o), m_sel);
    cmp("sec_en", "R7", int'(sec_en_o),
        int'(!m_busy && src_tick(m_sel, pll_tick_i, xtal_tick_i, ext_tick_i)));
    if (sec_sel_o == 2'b11) cmp("sec_sel code", "R8", 3, 0);
  endtask

  task automatic model_step();
    bit mt, lp;
    int tgt;
    mt = ext_mode_i ? ext_tick_i : pll_tick_i;
    lp = (m_mode != 0);
    tgt = want_src(ext_mode_i, lp, keep_pll_i);
    // selector handoff (R7)
    if (m_busy) begin
      if (m_scnt == HALFW-1) m_sel = tgt;
      if (m_scnt == 2*HALFW-1) begin m_busy = 0; m_scnt = 0; end
      else m_scnt++;
    end else if (tgt != m_sel) begin
      m_busy = 1; m_scnt = 0;
    end
    // strobe divider
    if (mt) m_ediv = (m_ediv == EDIVN-1) ? 0 : m_ediv + 1;
    // mode
    case (m_mode)
      0: if (stop_req_i) m_mode = 1;
      1: if (!stop_req_i && wake_req_i) begin m_mode = 2; m_cnt = 0; end
      default: begin
        if (stop_req_i) m_mode = 1;
        else if (m_cnt == SETTLE-1) m_mode = 0;
        else m_cnt++;
      end
    endcase
  endtask

  task automatic cycle(bit p, bit x, bit e, bit em, bit kp, bit st, bit wk);
    @(negedge clk_i);
    pll_tick_i = p; xtal_tick_i = x; ext_tick_i = e;
    ext_mode_i = em; keep_pll_i = kp; stop_req_i = st; wake_req_i = wk;
    #(CLK_PERIOD/4);
    if (!done) check_outputs();
    @(posedge clk_i);
    #1;
    model_step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    bit em, kp;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    // reset state, R1
    cmp("lp_active in reset", "R1", int'(lp_active_o), 0);
    cmp("sec_sel in reset", "R1", int'(sec_sel_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: divider starts at zero -> 8th clkout pulse carries e_en
    for (int i = 0; i < EDIVN; i++) cycle(1, 0, 0, 0, 0, 0, 0);
    // R3: wake while running is ignored; stop and wake together -> stop
    cycle(1, 1, 0, 0, 0, 0, 1);
    cycle(1, 1, 0, 0, 0, 1, 1);
    // R4: stay stopped, then wake and count the settle window
    for (int i = 0; i < 6; i++) cycle(1, 1, 0, 0, 0, 0, 0);
    cycle(1, 1, 0, 0, 0, 0, 1);
    for (int i = 0; i < SETTLE + 4; i++) cycle(1, 1, 1, 0, 0, 0, 0);
    // R4: stop during settle returns to stop
    cycle(1, 1, 1, 0, 1, 1, 0);
    for (int i = 0; i < 3; i++) cycle(1, 1, 1, 0, 1, 0, 0);
    cycle(1, 1, 1, 0, 1, 0, 1);
    for (int i = 0; i < 5; i++) cycle(1, 1, 1, 0, 1, 0, 0);
    cycle(1, 1, 1, 0, 1, 1, 0);
    for (int i = 0; i < 4; i++) cycle(1, 1, 1, 0, 1, 0, 0);
    cycle(0, 1, 1, 0, 0, 0, 1);
    for (int i = 0; i < SETTLE + 4; i++) cycle(1, 1, 1, 0, 0, 0, 0);
    // R6: external mode forces external source
    for (int i = 0; i < 10; i++) cycle(1, 0, 1, 1, 0, 0, 0);
    cycle(1, 0, 1, 1, 0, 1, 0);
    for (int i = 0; i < 10; i++) cycle(0, 1, 1, 1, 0, 0, 0);
    cycle(1, 1, 1, 1, 0, 0, 1);
    for (int i = 0; i < SETTLE + 4; i++) cycle(1, 1, 1, 1, 0, 0, 0);
    // constrained random phase
    em = 0; kp = 0;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 400) == 0) em = ~em;
      if (($urandom % 60) == 0) kp = ~kp;
      cycle($urandom % 2, $urandom % 2, $urandom % 2, em, kp,
            ($urandom % 40) == 0, ($urandom % 12) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule